// File: doc/BRIEF.md
# Trap Entry and Interrupt Sequencer

This block is the trap-entry control of a processor status unit for a register-windowed RISC core. It holds the processor status fields: trap enable, supervisor, previous supervisor, a 4-bit interrupt priority level and the current window pointer. It also holds the trap base register, which carries a base address and an 8-bit trap type field. Each cycle it looks at the synchronous trap request, the misaligned-access flag and the external interrupt level, and decides whether a trap is taken.

When a trap is taken, the block applies only changes that a return sequence can undo. Traps are disabled, the old supervisor bit moves into the previous-supervisor bit, and the window pointer steps down by one. The faulting PC and nPC are captured for the trap window's locals, and a new PC/nPC pair is produced from the trap base register. A synchronous trap that arrives while traps are disabled drives the unit into a sticky error mode. Reset is handled as a special trap entry.

The surrounding pipeline writes the status fields and the trap base address through a simple load port. It redirects fetch on the one-cycle trap strobe.

Top module: `trap_entry_seq`

## Requirements
- R1: While `rst` is high, at each clock edge the unit sets trap enable to 0, supervisor to 1, PC to 0, nPC to 4, clears error mode, and gives no trap strobe. Interrupt level, window pointer, previous-supervisor bit, trap base address and trap type keep their values.
- R2: On trap entry, trap enable becomes 0, the previous-supervisor bit takes the old supervisor bit, and the supervisor bit becomes 1.
- R3: On trap entry, the window pointer becomes (old - 1) modulo NWIN, so 0 wraps to NWIN-1.
- R4: On trap entry, `loc1_o` takes `pc_in` and `loc2_o` takes `npc_in` from the cycle the trap was accepted.
- R5: On trap entry, the trap type field is loaded with the trap's code. The new PC is {trap base address in bits XLEN-1:12, trap type in bits 11:4, 4'b0000}, and the new nPC is that value plus 4.
- R6: Trap entry leaves the interrupt level field unchanged.
- R7: With trap enable at 1, an interrupt request level L is taken when L is not 0 and L is greater than the interrupt level. Its trap type is 0x10 + L. A request at or below the interrupt level, or at level 0, changes nothing.
- R8: A level-15 request is taken even when the interrupt level is 15. Any interrupt request is ignored, without entering error mode, while trap enable is 0.
- R9: When a synchronous request and a takeable interrupt occur in the same cycle, the synchronous trap is taken with its own code.
- R10: The misaligned-access flag is a synchronous trap with type code 7. It wins over the code on `sync_tt` when both are present.
- R11: A synchronous or misaligned trap while trap enable is 0 sets `err_mode` and changes no other state. In error mode, all trap requests and status writes are ignored, and only reset clears it.
- R12: `trap_taken` is high for exactly the one cycle after each accepted trap and never for reset.
- R13: `st_wr` loads trap enable, supervisor, interrupt level and window pointer, and `tba_wr` loads the trap base address, both at the next edge. Both writes are ignored in a cycle where reset, a trap entry or error mode applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, treated as reset trap |
| pc_in | input | XLEN | PC of the instruction in execute |
| npc_in | input | XLEN | nPC of the instruction in execute |
| sync_req | input | 1 | Synchronous trap request |
| sync_tt | input | 8 | Trap type code of the synchronous request |
| misalign | input | 1 | Misaligned memory access detected |
| irq_lvl | input | 4 | External interrupt request level, 0 = none |
| st_wr | input | 1 | Load status fields |
| st_wr_et | input | 1 | Trap enable value to load |
| st_wr_s | input | 1 | Supervisor value to load |
| st_wr_pil | input | 4 | Interrupt level value to load |
| st_wr_cwp | input | CWP_W | Window pointer value to load |
| tba_wr | input | 1 | Load trap base address |
| tba_wr_val | input | XLEN-12 | Trap base address value |
| trap_taken | output | 1 | One-cycle trap entry strobe |
| err_mode | output | 1 | Sticky error mode |
| pc_o | output | XLEN | Redirect PC |
| npc_o | output | XLEN | Redirect nPC |
| loc1_o | output | XLEN | Saved PC for the trap window |
| loc2_o | output | XLEN | Saved nPC for the trap window |
| et_o | output | 1 | Trap enable |
| s_o | output | 1 | Supervisor mode |
| ps_o | output | 1 | Previous supervisor mode |
| pil_o | output | 4 | Interrupt priority level |
| cwp_o | output | CWP_W | Current window pointer |
| tba_o | output | XLEN-12 | Trap base address |
| tt_o | output | 8 | Trap type field |

## Verification
The assertions check several properties on every cycle:
- the reset values after reset releases;
- the reversible status changes and the window pointer step on each strobe;
- the unchanged interrupt level and the PC/nPC vector formed from the trap base register;
- the absence of a strobe while traps were disabled;
- the stickiness of error mode and the single-cycle strobe.

Only the bench's scenarios show which request wins a cycle and which trap type code gets chosen. This covers the level comparison and the level-15 exception, the priority of synchronous over asynchronous requests, and the misaligned code 7. They also show that writes are dropped during trap entry and error mode, and that status fields survive a reset.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int TT_W = 8;
    localparam logic [TT_W-1:0] TT_MISALIGN = 8'h07;
    localparam logic [TT_W-1:0] TT_IRQ_BASE = 8'h10;
    localparam logic [3:0]      LVL_NMI     = 4'hF;

    typedef enum logic [1:0] {
        DEC_NONE  = 2'd0,
        DEC_SYNC  = 2'd1,
        DEC_IRQ   = 2'd2,
        DEC_ERROR = 2'd3
    } trap_dec_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic            et,
    input  logic            err,
    input  logic [3:0]      pil,
    input  logic [3:0]      irq_lvl,
    input  logic            sync_req,
    input  logic            misalign,
    input  logic [TT_W-1:0] sync_tt,
    output trap_dec_e       dec,
    output logic [TT_W-1:0] tt_sel
);
    logic sync_any;
    logic irq_ok;

    always_comb begin
        sync_any = sync_req | misalign;
        irq_ok   = et && (irq_lvl != 4'd0) && ((irq_lvl == LVL_NMI) || (irq_lvl > pil));

        if (err)           dec = DEC_NONE;
        else if (sync_any) dec = et ? DEC_SYNC : DEC_ERROR;
        else if (irq_ok)   dec = DEC_IRQ;
        else               dec = DEC_NONE;

        if (misalign)      tt_sel = TT_MISALIGN;
        else if (sync_req) tt_sel = sync_tt;
        else               tt_sel = TT_IRQ_BASE + TT_W'(irq_lvl);
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-TT_W-5:0] tba,
    input  logic [TT_W-1:0]      tt,
    output logic [XLEN-1:0]      vec_pc,
    output logic [XLEN-1:0]      vec_npc
);
    always_comb begin
        vec_pc  = {tba, tt, 4'b0000};
        vec_npc = vec_pc + XLEN'(4);
    end
endmodule

// File: rtl/cwp_step.sv
module cwp_step #(
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  logic [CWP_W-1:0] cwp,
    output logic [CWP_W-1:0] cwp_dn
);
    generate
        if ((1 << CWP_W) == NWIN) begin : g_pow2
            assign cwp_dn = cwp - 1'b1;
        end else begin : g_generic
            assign cwp_dn = (cwp == '0) ? CWP_W'(NWIN - 1) : cwp - 1'b1;
        end
    endgenerate
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [XLEN-1:0]      pc_in,
    input  logic [XLEN-1:0]      npc_in,
    input  logic                 sync_req,
    input  logic [7:0]           sync_tt,
    input  logic                 misalign,
    input  logic [3:0]           irq_lvl,
    input  logic                 st_wr,
    input  logic                 st_wr_et,
    input  logic                 st_wr_s,
    input  logic [3:0]           st_wr_pil,
    input  logic [CWP_W-1:0]     st_wr_cwp,
    input  logic                 tba_wr,
    input  logic [XLEN-13:0]     tba_wr_val,
    output logic                 trap_taken,
    output logic                 err_mode,
    output logic [XLEN-1:0]      pc_o,
    output logic [XLEN-1:0]      npc_o,
    output logic [XLEN-1:0]      loc1_o,
    output logic [XLEN-1:0]      loc2_o,
    output logic                 et_o,
    output logic                 s_o,
    output logic                 ps_o,
    output logic [3:0]           pil_o,
    output logic [CWP_W-1:0]     cwp_o,
    output logic [XLEN-13:0]     tba_o,
    output logic [7:0]           tt_o
);
    localparam int TBA_W = XLEN - TT_W - 4;

    typedef struct packed {
        logic             et;
        logic             s;
        logic             ps;
        logic [3:0]       pil;
        logic [CWP_W-1:0] cwp;
        logic [TBA_W-1:0] tba;
        logic [TT_W-1:0]  tt;
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  npc;
        logic [XLEN-1:0]  loc1;
        logic [XLEN-1:0]  loc2;
        logic             err;
        logic             taken;
    } state_t;

    state_t st_d, st_q;

    trap_dec_e        dec;
    logic [TT_W-1:0]  tt_sel;
    logic [XLEN-1:0]  vec_pc, vec_npc;
    logic [CWP_W-1:0] cwp_dn;

    trap_arbiter u_arb (
        .et       (st_q.et),
        .err      (st_q.err),
        .pil      (st_q.pil),
        .irq_lvl  (irq_lvl),
        .sync_req (sync_req),
        .misalign (misalign),
        .sync_tt  (sync_tt),
        .dec      (dec),
        .tt_sel   (tt_sel)
    );

    trap_vector #(.XLEN(XLEN)) u_vec (
        .tba     (st_q.tba),
        .tt      (tt_sel),
        .vec_pc  (vec_pc),
        .vec_npc (vec_npc)
    );

    cwp_step #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
        .cwp    (st_q.cwp),
        .cwp_dn (cwp_dn)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (rst) begin
            st_d.et  = 1'b0;
            st_d.s   = 1'b1;
            st_d.pc  = '0;
            st_d.npc = XLEN'(4);
            st_d.err = 1'b0;
        end else begin
            case (dec)
                DEC_ERROR: st_d.err = 1'b1;
                DEC_SYNC, DEC_IRQ: begin
                    st_d.et    = 1'b0;
                    st_d.ps    = st_q.s;
                    st_d.s     = 1'b1;
                    st_d.cwp   = cwp_dn;
                    st_d.tt    = tt_sel;
                    st_d.pc    = vec_pc;
                    st_d.npc   = vec_npc;
                    st_d.loc1  = pc_in;
                    st_d.loc2  = npc_in;
                    st_d.taken = 1'b1;
                end
                default: begin
                    if (!st_q.err) begin
                        if (st_wr) begin
                            st_d.et  = st_wr_et;
                            st_d.s   = st_wr_s;
                            st_d.pil = st_wr_pil;
                            st_d.cwp = st_wr_cwp;
                        end
                        if (tba_wr) st_d.tba = tba_wr_val;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign trap_taken = st_q.taken;
    assign err_mode   = st_q.err;
    assign pc_o       = st_q.pc;
    assign npc_o      = st_q.npc;
    assign loc1_o     = st_q.loc1;
    assign loc2_o     = st_q.loc2;
    assign et_o       = st_q.et;
    assign s_o        = st_q.s;
    assign ps_o       = st_q.ps;
    assign pil_o      = st_q.pil;
    assign cwp_o      = st_q.cwp;
    assign tba_o      = st_q.tba;
    assign tt_o       = st_q.tt;

    // R1: reset values are visible once reset releases
    p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!et_o && s_o && pc_o == '0 && npc_o == XLEN'(4) && !err_mode && !trap_taken));

    // R2: reversible status changes on trap entry
    p_entry_status_r2: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> (!et_o && s_o && ps_o == $past(s_o)));

    // R3: window pointer steps down modulo the window count
    p_cwp_step_r3: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> (cwp_o == (($past(cwp_o) == '0) ? CWP_W'(NWIN - 1) : CWP_W'($past(cwp_o) - 1'b1))));

    // R4: locals capture the interrupted PC pair
    p_locals_r4: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> (loc1_o == $past(pc_in) && loc2_o == $past(npc_in)));

    // R5: redirect vector built from the trap base register
    p_vector_r5: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> (pc_o == {tba_o, tt_o, 4'b0000} && npc_o == pc_o + XLEN'(4)));

    // R6: interrupt level untouched by trap entry
    p_pil_kept_r6: assert property (@(posedge clk) disable iff (rst)
        trap_taken |-> $stable(pil_o));

    // R8: nothing is taken while traps were disabled
    p_no_take_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(et_o) |-> !trap_taken);

    // R11: error mode is sticky outside reset
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        $past(err_mode) && !$past(rst) |-> err_mode);

    // R12: strobe lasts one cycle
    p_strobe_single_r12: assert property (@(posedge clk) disable iff (rst)
        trap_taken |=> !trap_taken);
endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
    localparam int XLEN  = 32;
    localparam int NWIN  = 8;
    localparam int CWP_W = 3;

    logic clk = 1'b0;
    logic rst;
    logic [XLEN-1:0] pc_in, npc_in;
    logic sync_req, misalign, st_wr, st_wr_et, st_wr_s, tba_wr;
    logic [7:0] sync_tt;
    logic [3:0] irq_lvl, st_wr_pil;
    logic [CWP_W-1:0] st_wr_cwp;
    logic [XLEN-13:0] tba_wr_val;
    logic trap_taken, err_mode, et_o, s_o, ps_o;
    logic [XLEN-1:0] pc_o, npc_o, loc1_o, loc2_o;
    logic [3:0] pil_o;
    logic [CWP_W-1:0] cwp_o;
    logic [XLEN-13:0] tba_o;
    logic [7:0] tt_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    trap_entry_seq #(.XLEN(XLEN), .NWIN(NWIN)) u0 (.*);

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        sync_req = 0; misalign = 0; sync_tt = 0; irq_lvl = 0;
        st_wr = 0; st_wr_et = 0; st_wr_s = 0; st_wr_pil = 0; st_wr_cwp = 0;
        tba_wr = 0; tba_wr_val = 0;
    endtask

    task automatic setst(input logic et, input logic s, input logic [3:0] pil, input logic [CWP_W-1:0] cwp);
        st_wr = 1; st_wr_et = et; st_wr_s = s; st_wr_pil = pil; st_wr_cwp = cwp;
        cyc();
        idle();
    endtask

    task automatic t_reset();
        rst = 1; cyc(); cyc();
        rst = 0;
        chk("R1", "et", et_o, 0);
        chk("R1", "s", s_o, 1);
        chk("R1", "pc", pc_o, 0);
        chk("R1", "npc", npc_o, 4);
        chk("R1", "err", err_mode, 0);
        chk("R12", "no strobe at reset", trap_taken, 0);
        tba_wr = 1; tba_wr_val = 20'h12345;
        setst(1, 0, 5, 3);
        chk("R13", "pil loaded", pil_o, 5);
        chk("R13", "cwp loaded", cwp_o, 3);
        chk("R13", "tba loaded", tba_o, 32'h12345);
        chk("R13", "et loaded", et_o, 1);
        rst = 1; cyc(); rst = 0;
        chk("R1", "pil kept", pil_o, 5);
        chk("R1", "cwp kept", cwp_o, 3);
        chk("R1", "tba kept", tba_o, 32'h12345);
        chk("R1", "s after reset", s_o, 1);
    endtask

    task automatic t_sync();
        setst(1, 0, 5, 3);
        pc_in = 32'h1000; npc_in = 32'h1004;
        sync_req = 1; sync_tt = 8'h2A;
        cyc(); idle();
        chk("R12", "strobe", trap_taken, 1);
        chk("R2", "et", et_o, 0);
        chk("R2", "ps", ps_o, 0);
        chk("R2", "s", s_o, 1);
        chk("R3", "cwp", cwp_o, 2);
        chk("R6", "pil", pil_o, 5);
        chk("R4", "loc1", loc1_o, 32'h1000);
        chk("R4", "loc2", loc2_o, 32'h1004);
        chk("R5", "tt", tt_o, 8'h2A);
        chk("R5", "pc", pc_o, 32'h123452A0);
        chk("R5", "npc", npc_o, 32'h123452A4);
        cyc();
        chk("R12", "strobe drops", trap_taken, 0);
    endtask

    task automatic t_wrap();
        setst(1, 1, 0, 0);
        sync_req = 1; sync_tt = 8'h11;
        cyc(); idle();
        chk("R3", "cwp wrap", cwp_o, NWIN - 1);
        chk("R2", "ps from s=1", ps_o, 1);
    endtask

    task automatic t_irq();
        setst(1, 0, 5, 4);
        irq_lvl = 5; cyc(); idle();
        chk("R7", "equal level ignored", trap_taken, 0);
        chk("R7", "et unchanged", et_o, 1);
        chk("R7", "cwp unchanged", cwp_o, 4);
        irq_lvl = 6; cyc(); idle();
        chk("R7", "higher level taken", trap_taken, 1);
        chk("R7", "tt", tt_o, 8'h16);
        chk("R5", "irq pc", pc_o, 32'h12345160);
        setst(1, 0, 0, 4);
        irq_lvl = 0; cyc(); idle();
        chk("R7", "level 0 ignored", trap_taken, 0);
    endtask

    task automatic t_nmi();
        setst(1, 0, 15, 4);
        irq_lvl = 14; cyc(); idle();
        chk("R7", "14 below pil 15", trap_taken, 0);
        irq_lvl = 15; cyc(); idle();
        chk("R8", "level 15 taken", trap_taken, 1);
        chk("R8", "tt", tt_o, 8'h1F);
        irq_lvl = 15; cyc(); idle();
        chk("R8", "15 blocked when et=0", trap_taken, 0);
        chk("R8", "no error from irq", err_mode, 0);
    endtask

    task automatic t_prio();
        setst(1, 0, 0, 4);
        sync_req = 1; sync_tt = 8'h05; irq_lvl = 14;
        cyc(); idle();
        chk("R9", "sync wins", tt_o, 8'h05);
        chk("R9", "pc", pc_o, 32'h12345050);
        setst(1, 0, 0, 4);
        misalign = 1; sync_req = 1; sync_tt = 8'h2A;
        cyc(); idle();
        chk("R10", "misaligned code", tt_o, 8'h07);
        chk("R10", "pc", pc_o, 32'h12345070);
    endtask

    task automatic t_wr_ignored();
        setst(1, 0, 5, 4);
        sync_req = 1; sync_tt = 8'h22;
        st_wr = 1; st_wr_et = 1; st_wr_pil = 9; st_wr_cwp = 1;
        tba_wr = 1; tba_wr_val = 20'hABCDE;
        cyc(); idle();
        chk("R13", "trap still taken", trap_taken, 1);
        chk("R13", "pil write dropped", pil_o, 5);
        chk("R13", "cwp from trap", cwp_o, 3);
        chk("R13", "tba write dropped", tba_o, 32'h12345);
    endtask

    task automatic t_err();
        setst(0, 1, 5, 4);
        sync_req = 1; sync_tt = 8'h30;
        cyc(); idle();
        chk("R11", "err set", err_mode, 1);
        chk("R11", "no strobe", trap_taken, 0);
        chk("R11", "cwp unchanged", cwp_o, 4);
        st_wr = 1; st_wr_et = 1; st_wr_pil = 2; irq_lvl = 9;
        cyc(); idle();
        chk("R11", "write ignored", et_o, 0);
        chk("R11", "pil ignored", pil_o, 5);
        chk("R11", "still err", err_mode, 1);
        chk("R11", "irq ignored", trap_taken, 0);
        cyc();
        chk("R11", "sticky", err_mode, 1);
        rst = 1; cyc(); rst = 0;
        chk("R11", "reset clears err", err_mode, 0);
    endtask

    initial begin
        idle();
        pc_in = 0; npc_in = 0; rst = 1;
        t_reset();
        t_sync();
        t_wrap();
        t_irq();
        t_nmi();
        t_prio();
        t_wr_ignored();
        t_err();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule